// File: doc/BRIEF.md
# Cascading Event Counter Bank

A bank of six event counters, each paired with a configuration register. It is used for performance monitoring. Every counter has its own event strobe. Software can load a counter with the two's complement of a target count, so the counter overflows on exactly that event. The counter then keeps counting past zero. Each overflow sets a sticky status bit. If the counter's interrupt-enable bit is set, that status bit drives the shared interrupt line.

A counter can be armed instead of started. To arm it, software sets its cascade bit and leaves its enable bit clear. An armed counter holds its value until its source counter overflows. At that moment the hardware sets the armed counter's enable bit, and the counter counts its own events from the next cycle on.

By default a counter's source is the counter with the index one below it; counter 0 takes counter 5. Bit 11 of four configuration registers selects a fixed alternate source instead. Counters 1 and 2 have no alternate source, so bit 11 is reserved there. When one event stream is counted across a cascaded pair, the total number of events is the sum of the two counts.

Top module: `cec_bank`

## Requirements
- R1: After reset, every counter and configuration register reads zero and `irq_o` is low.
- R2: A counter advances by one on each clock in which its event strobe is high and its enable bit (config bit 0) is set. While the enable bit is clear, the counter holds its value.
- R3: An increment that carries out of the top counter bit is an overflow. A counter preset to 2^CW−N overflows on its Nth counted event and sets its status bit (config bit 3).
- R4: After an overflow the counter wraps to zero and keeps counting.
- R5: A counter with its cascade bit (config bit 1) set and its enable bit clear stays idle until its source counter overflows. Its enable bit then reads back as 1, and it counts from the following cycle. The default source of counter i is counter (i+5) mod 6.
- R6: When config bit 11 is set, the source is replaced as follows: counter 0 takes counter 4, counter 3 takes counter 5, counter 4 takes counter 5, and counter 5 takes counter 4.
- R7: In counters 1 and 2, config bit 11 ignores writes, reads as zero and does not change the cascade source.
- R8: The status bit is sticky. A configuration write clears it only when the write has bit 3 set. An overflow in the same cycle as a clearing write leaves the bit set.
- R9: `irq_o` is high exactly when some counter has both its status bit and its interrupt-enable bit (config bit 2) set.
- R10: A register write to a counter takes priority over an event in the same cycle. The written value is stored, and no overflow is raised for that cycle.
- R11: Counter i reads and writes at address 2i and its configuration at 2i+1. Addresses beyond 2·NCNT−1 read zero.
- R12: When one event stream drives both counters of a cascaded pair, the number of events equals the first counter's preset distance to overflow plus the second counter's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NCNT | Per-counter event strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the bank with CW=8 and DW=16, which makes an 8-bit counter's full range reachable in a few hundred cycles. That lets the bench sweep every preset distance from 1 to 255 and check that the status bit stays clear one event before the overflow and is set on it. The narrow counter also brings wraparound, every cascade route and the cascade sum into short, exactly predictable event bursts.

// File: rtl/cec_pkg.sv
package cec_pkg;
    localparam int B_EN  = 0;
    localparam int B_CAS = 1;
    localparam int B_IE  = 2;
    localparam int B_OVF = 3;
    localparam int B_XC  = 11;

    typedef struct packed {
        logic xc;
        logic ovf;
        logic ie;
        logic cas;
        logic en;
    } cfg_t;

    // Alternate cascade source selected by bit 11; -1 when reserved
    function automatic int xc_source(input int idx);
        case (idx)
            0:       return 4;
            3:       return 5;
            4:       return 5;
            5:       return 4;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/cec_slice.sv
module cec_slice #(
    parameter int CW    = 40,
    parameter int DW    = 40,
    parameter bit XC_OK = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_i,
    input  logic               cnt_we_i,
    input  logic               cfg_we_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic               start_i,
    output logic [CW-1:0]      cnt_o,
    output cec_pkg::cfg_t      cfg_o,
    output logic               ovf_o
);
    import cec_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        cfg_t          cfg;
    } st_t;

    st_t st_d, st_q;
    logic          inc;
    logic          carry;
    logic [CW-1:0] sum;

    always_comb begin
        st_d  = st_q;
        inc   = st_q.cfg.en & evt_i;
        {carry, sum} = {1'b0, st_q.cnt} + (CW+1)'(1);
        ovf_o = inc & carry & ~cnt_we_i;

        if (cnt_we_i)
            st_d.cnt = wdata_i[CW-1:0];
        else if (inc)
            st_d.cnt = sum;

        if (cfg_we_i) begin
            st_d.cfg.en  = wdata_i[B_EN];
            st_d.cfg.cas = wdata_i[B_CAS];
            st_d.cfg.ie  = wdata_i[B_IE];
            st_d.cfg.xc  = XC_OK ? wdata_i[B_XC] : 1'b0;
            if (wdata_i[B_OVF])
                st_d.cfg.ovf = 1'b0;
        end else if (start_i && st_q.cfg.cas && !st_q.cfg.en) begin
            st_d.cfg.en = 1'b1;
        end

        if (ovf_o)
            st_d.cfg.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign cfg_o = st_q.cfg;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cfg.en && !cnt_we_i) |=> $stable(st_q.cnt));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (st_q.cnt == '0));

    p_autostart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q.cfg.cas && !st_q.cfg.en && !cfg_we_i) |=> st_q.cfg.en);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.ovf && !(cfg_we_i && wdata_i[B_OVF])) |=> st_q.cfg.ovf);
endmodule

// File: rtl/cec_route.sv
module cec_route #(
    parameter int NCNT = 6
) (
    input  logic [NCNT-1:0] ovf_i,
    input  logic [NCNT-1:0] xc_i,
    output logic [NCNT-1:0] start_o
);
    for (genvar i = 0; i < NCNT; i++) begin : g_src
        localparam int BASE = (i + NCNT - 1) % NCNT;
        localparam int XSRC = cec_pkg::xc_source(i);
        if (XSRC >= 0 && XSRC < NCNT) begin : g_alt
            assign start_o[i] = xc_i[i] ? ovf_i[XSRC] : ovf_i[BASE];
        end else begin : g_base
            assign start_o[i] = ovf_i[BASE];
        end
    end
endmodule

// File: rtl/cec_bank.sv
module cec_bank #(
    parameter int NCNT = 6,
    parameter int CW   = 40,
    parameter int DW   = 40,
    parameter int AW   = $clog2(2 * NCNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCNT-1:0] evt_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o
);
    import cec_pkg::*;

    localparam int NREG = 2 * NCNT;

    logic [CW-1:0]   cnt_w [NCNT];
    cfg_t            cfg_w [NCNT];
    logic [NCNT-1:0] ovf_w;
    logic [NCNT-1:0] xc_w;
    logic [NCNT-1:0] start_w;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        localparam int  XS = xc_source(i);
        localparam bit  OK = (XS >= 0) && (XS < NCNT);
        logic cnt_we, cfg_we;
        assign cnt_we = wr_en_i && (int'(addr_i) == 2 * i);
        assign cfg_we = wr_en_i && (int'(addr_i) == 2 * i + 1);
        cec_slice #(.CW(CW), .DW(DW), .XC_OK(OK)) slice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[i]),
            .cnt_we_i (cnt_we),
            .cfg_we_i (cfg_we),
            .wdata_i  (wdata_i),
            .start_i  (start_w[i]),
            .cnt_o    (cnt_w[i]),
            .cfg_o    (cfg_w[i]),
            .ovf_o    (ovf_w[i])
        );
        assign xc_w[i] = cfg_w[i].xc;
    end

    cec_route #(.NCNT(NCNT)) route_i (
        .ovf_i   (ovf_w),
        .xc_i    (xc_w),
        .start_o (start_w)
    );

    always_comb begin
        rdata_o = '0;
        irq_o   = 1'b0;
        for (int i = 0; i < NCNT; i++) begin
            if (int'(addr_i) == 2 * i)
                rdata_o = DW'(cnt_w[i]);
            if (int'(addr_i) == 2 * i + 1) begin
                rdata_o[B_EN]  = cfg_w[i].en;
                rdata_o[B_CAS] = cfg_w[i].cas;
                rdata_o[B_IE]  = cfg_w[i].ie;
                rdata_o[B_OVF] = cfg_w[i].ovf;
                rdata_o[B_XC]  = cfg_w[i].xc;
            end
            irq_o = irq_o | (cfg_w[i].ovf & cfg_w[i].ie);
        end
        if (int'(addr_i) >= NREG)
            rdata_o = '0;
    end

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) >= NREG) |-> (rdata_o == '0));
endmodule

// File: tb/cec_bank_tb_top.sv
module cec_bank_tb_top;
    localparam int NCNT = 6;
    localparam int CW   = 8;
    localparam int DW   = 16;
    localparam int AW   = $clog2(2 * NCNT);
    localparam int EN = 1, CAS = 2, IE = 4, OVF = 8, XC = 2048;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCNT-1:0] evt = '0;
    logic            we = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cec_bank #(.NCNT(NCNT), .CW(CW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; evt = '0; we = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); we = 1'b1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); addr = AW'(a); #1 v = int'(rdata);
    endtask

    task automatic pulse(input int mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt = NCNT'(mask);
        end
        @(negedge clk); evt = '0;
    endtask

    initial begin
        int v;
        do_reset();
        // R1 and R11: all registers zero after reset, unmapped reads zero
        for (int a = 0; a < (1 << AW); a++) begin
            rd(a, v); chk("R1/R11 reset read", v, 0);
        end
        chk("R1 irq after reset", int'(irq), 0);

        // R3: sweep every preset distance on counter 0
        for (int n = 1; n < 256; n++) begin
            wr(0, 256 - n);
            wr(1, EN | OVF);
            if (n > 1) pulse(1, n - 1);
            rd(1, v); chk("R3 no overflow before Nth event", (v >> 3) & 1, 0);
            pulse(1, 1);
            rd(1, v); chk("R3 overflow on Nth event", (v >> 3) & 1, 1);
            rd(0, v); chk("R4 wraps to zero", v, 0);
        end
        pulse(1, 3);
        rd(0, v); chk("R4 keeps counting after wrap", v, 3);

        // R2: hold while disabled, count while enabled
        do_reset();
        wr(4, 10);
        pulse(4, 5);
        rd(4, v); chk("R2 hold when disabled", v, 10);
        wr(5, EN);
        pulse(4, 5);
        rd(4, v); chk("R2 count when enabled", v, 15);

        // R5: default cascade 0 -> 1
        do_reset();
        wr(3, CAS);
        wr(0, 253);
        wr(1, EN);
        pulse(3, 2);
        rd(2, v); chk("R5 idle before source overflow", v, 0);
        rd(3, v); chk("R5 enable still clear", v & 1, 0);
        pulse(3, 1);
        rd(3, v); chk("R5 enable set by overflow", v & 1, 1);
        rd(2, v); chk("R5 overflow-cycle event not counted", v, 0);
        pulse(2, 4);
        rd(2, v); chk("R5 counts after start", v, 4);

        // R12: one stream across a cascaded pair
        do_reset();
        wr(3, CAS);
        wr(0, 251);
        wr(1, EN);
        pulse(3, 12);
        rd(2, v); chk("R12 sum 5 + second count", 5 + v, 12);
        rd(0, v); chk("R12 first counter wrapped", v, 7);

        // R6/R7: counter 4 overflow starts 0 and 5 via bit 11; 1 ignores bit 11
        do_reset();
        wr(1, CAS | XC);
        wr(11, CAS | XC);
        wr(3, CAS | XC);
        rd(3, v); chk("R7 bit 11 reads zero in counter 1", (v >> 11) & 1, 0);
        wr(5, XC);
        rd(5, v); chk("R7 bit 11 reads zero in counter 2", (v >> 11) & 1, 0);
        wr(8, 255);
        wr(9, EN);
        pulse(16, 1);
        rd(1, v); chk("R6 counter 4 starts counter 0", v & 1, 1);
        rd(11, v); chk("R6 counter 4 starts counter 5", v & 1, 1);
        rd(3, v); chk("R7 counter 1 not started by counter 4", v & 1, 0);

        // R6: counter 5 overflow starts 3 and 4
        do_reset();
        wr(7, CAS | XC);
        wr(9, CAS | XC);
        wr(10, 255);
        wr(11, EN);
        pulse(32, 1);
        rd(7, v); chk("R6 counter 5 starts counter 3", v & 1, 1);
        rd(9, v); chk("R6 counter 5 starts counter 4", v & 1, 1);

        // R8/R9: sticky status and interrupt gating
        do_reset();
        wr(6, 255);
        wr(7, EN);
        pulse(8, 1);
        rd(7, v); chk("R8 status set", (v >> 3) & 1, 1);
        chk("R9 irq low without enable", int'(irq), 0);
        wr(7, EN | IE);
        rd(7, v); chk("R8 status kept without clear bit", (v >> 3) & 1, 1);
        chk("R9 irq high", int'(irq), 1);
        pulse(8, 2);
        rd(7, v); chk("R8 status sticky over events", (v >> 3) & 1, 1);
        wr(7, EN | IE | OVF);
        rd(7, v); chk("R8 status cleared", (v >> 3) & 1, 0);
        chk("R9 irq low after clear", int'(irq), 0);

        // R10: write wins over an event in the same cycle
        do_reset();
        wr(1, EN | IE);
        wr(0, 255);
        @(negedge clk); we = 1'b1; addr = AW'(0); wdata = DW'(85); evt = NCNT'(1);
        @(negedge clk); we = 1'b0; evt = '0;
        rd(0, v); chk("R10 write priority value", v, 85);
        rd(1, v); chk("R10 no overflow on write cycle", (v >> 3) & 1, 0);
        chk("R10 irq stays low", int'(irq), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule